// File: doc/BRIEF.md
# Narrow-to-Wide Bus Width Bridge

This block joins a host that issues 32-bit TileLink-UL requests to a device port that is 128 bits wide. Each narrow request becomes exactly one wide request. The address goes through untouched. The write data and the 4-bit byte mask are moved into the 32-bit lane that address bits [3:2] select, and every other lane carries zero data and a zero mask.

The device answers with 128 bits of data. The wanted word sits in the lane named by the original request address. The bridge therefore records, for every request in flight, the host's source ID and the lane index. It keeps these in a small slot table. The index of the slot becomes the source ID on the wide side. When the device responds, its source ID selects the slot again. The bridge then:

- shifts the chosen lane down to 32 bits;
- restores the host's source ID;
- frees the slot.

Responses may return in any order. When every slot is occupied, the bridge stops accepting requests.

Top module: `nw_width_bridge`

## Requirements
- R1: While reset is high and in the cycle after it is released, `w_a_valid` and `n_d_valid` are 0 and `n_a_ready` is 1.
- R2: The wide write data carries the narrow data in lane L = `n_a_address[3:2]`, meaning bits [32L+31:32L], and zero in every other lane.
- R3: The wide mask equals the narrow 4-bit mask shifted left by 4*L.
- R4: Address, opcode and size of a request reach the wide port unchanged. Examples: Get is opcode 4, PutFullData is opcode 0, PutPartialData is opcode 1.
- R5: The wide source ID is the lowest-numbered free slot at the moment the host handshake completes. A slot stays occupied until a response carrying its number is accepted.
- R6: The narrow response data is lane L of the wide response data, where L is the lane recorded for the slot that the response's source ID names. This holds whatever order responses arrive in.
- R7: The narrow response carries the host source ID recorded in that slot. It also forwards the device's opcode (AccessAck 0, AccessAckData 1), size and error bit unchanged.
- R8: While all slots are occupied, `n_a_ready` is 0. It returns to 1 after a response frees a slot.
- R9: A registered output whose ready is low keeps its valid high and its payload unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| n_a_valid | input | 1 | Host request valid |
| n_a_ready | output | 1 | Host request ready |
| n_a_opcode | input | 3 | Host request opcode |
| n_a_size | input | 3 | Host request size (log2 bytes) |
| n_a_source | input | HSRC_W | Host source ID |
| n_a_address | input | ADDR_W | Host byte address |
| n_a_mask | input | NARROW_W/8 | Host byte mask |
| n_a_data | input | NARROW_W | Host write data |
| n_d_valid | output | 1 | Host response valid |
| n_d_ready | input | 1 | Host response ready |
| n_d_opcode | output | 3 | Host response opcode |
| n_d_size | output | 3 | Host response size |
| n_d_source | output | HSRC_W | Restored host source ID |
| n_d_data | output | NARROW_W | Extracted response word |
| n_d_error | output | 1 | Response error |
| w_a_valid | output | 1 | Device request valid |
| w_a_ready | input | 1 | Device request ready |
| w_a_opcode | output | 3 | Device request opcode |
| w_a_size | output | 3 | Device request size |
| w_a_source | output | SLOT_W | Slot number used as source ID |
| w_a_address | output | ADDR_W | Device byte address |
| w_a_mask | output | WIDE_W/8 | Lane-shifted byte mask |
| w_a_data | output | WIDE_W | Lane-placed write data |
| w_d_valid | input | 1 | Device response valid |
| w_d_ready | output | 1 | Device response ready |
| w_d_opcode | input | 3 | Device response opcode |
| w_d_size | input | 3 | Device response size |
| w_d_source | input | SLOT_W | Device response source ID |
| w_d_data | input | WIDE_W | Device response data |
| w_d_error | input | 1 | Device response error |

## Verification
Requests go to all four lanes, using full and partial masks. A lane placement or mask shift that is off by one lane shows up as a mismatch at exactly one address.

Reads get wide responses in which each lane holds a different word. A response that picked the wrong lane therefore returns a visibly wrong value.

One test fills the table with reads to four different lanes, confirms that the host is stalled, and then answers the reads out of order. This tells per-slot lane and source tracking apart from a design that only remembers the last request. Backpressure is applied on both output registers to separate holding the payload from dropping or overwriting it.

// File: rtl/nw_pkg.sv
package nw_pkg;
  typedef logic [2:0] tl_op_t;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/nw_slot_table.sv
module nw_slot_table #(
  parameter int SLOTS  = 4,
  parameter int HSRC_W = 4,
  parameter int LANE_W = 2,
  localparam int SLOT_W = nw_pkg::idx_bits(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [HSRC_W-1:0] alloc_src,
  input  logic [LANE_W-1:0] alloc_lane,
  output logic              avail,
  output logic [SLOT_W-1:0] alloc_idx,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_idx,
  output logic [HSRC_W-1:0] rd_src,
  output logic [LANE_W-1:0] rd_lane
);
  logic [SLOTS-1:0]  busy_q;
  logic [HSRC_W-1:0] src_mem  [SLOTS];
  logic [LANE_W-1:0] lane_mem [SLOTS];

  // lowest free slot wins: scan downward so the last hit is the smallest index
  always_comb begin
    alloc_idx = '0;
    avail     = 1'b0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        alloc_idx = SLOT_W'(i);
        avail     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (alloc_en && alloc_idx == SLOT_W'(i))
          busy_q[i] <= 1'b1;
        else if (free_en && free_idx == SLOT_W'(i))
          busy_q[i] <= 1'b0;
      end
    end
  end

  // payload storage without reset so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (alloc_en) begin
      src_mem[alloc_idx]  <= alloc_src;
      lane_mem[alloc_idx] <= alloc_lane;
    end
  end

  assign rd_src  = src_mem[free_idx];
  assign rd_lane = lane_mem[free_idx];

  // R5: a request is only taken when a slot is free
  p_alloc_when_free_r5: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> avail);
  // R6: a response must name a slot that is in flight
  p_free_only_busy_r6: assert property (@(posedge clk) disable iff (rst)
    free_en |-> busy_q[free_idx]);
endmodule

// File: rtl/nw_req_pack.sv
module nw_req_pack #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 128,
  parameter int DSRC_W   = 2,
  localparam int LANES   = WIDE_W / NARROW_W,
  localparam int LANE_W  = nw_pkg::idx_bits(LANES),
  localparam int NMASK_W = NARROW_W / 8,
  localparam int WMASK_W = WIDE_W / 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  nw_pkg::tl_op_t      in_op,
  input  logic [2:0]          in_sz,
  input  logic [DSRC_W-1:0]   in_src,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [NMASK_W-1:0]  in_mask,
  input  logic [NARROW_W-1:0] in_data,
  input  logic [LANE_W-1:0]   in_lane,
  output logic                out_valid,
  input  logic                out_ready,
  output nw_pkg::tl_op_t      out_op,
  output logic [2:0]          out_sz,
  output logic [DSRC_W-1:0]   out_src,
  output logic [ADDR_W-1:0]   out_addr,
  output logic [WMASK_W-1:0]  out_mask,
  output logic [WIDE_W-1:0]   out_data
);
  logic [WIDE_W-1:0]  data_w;
  logic [WMASK_W-1:0] mask_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_w[l*NARROW_W +: NARROW_W] = (in_lane == LANE_W'(l)) ? in_data : '0;
    assign mask_w[l*NMASK_W +: NMASK_W]   = (in_lane == LANE_W'(l)) ? in_mask : '0;
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_op   <= in_op;
      out_sz   <= in_sz;
      out_src  <= in_src;
      out_addr <= in_addr;
      out_mask <= mask_w;
      out_data <= data_w;
    end
  end

  // R9: stalled request holds
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)
                                   && $stable(out_mask) && $stable(out_src)));
endmodule

// File: rtl/nw_rsp_unpack.sv
module nw_rsp_unpack #(
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 128,
  parameter int HSRC_W   = 4,
  localparam int LANES   = WIDE_W / NARROW_W,
  localparam int LANE_W  = nw_pkg::idx_bits(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  nw_pkg::tl_op_t      in_op,
  input  logic [2:0]          in_sz,
  input  logic                in_err,
  input  logic [WIDE_W-1:0]   in_data,
  input  logic [HSRC_W-1:0]   in_src,
  input  logic [LANE_W-1:0]   in_lane,
  output logic                out_valid,
  input  logic                out_ready,
  output nw_pkg::tl_op_t      out_op,
  output logic [2:0]          out_sz,
  output logic [HSRC_W-1:0]   out_src,
  output logic [NARROW_W-1:0] out_data,
  output logic                out_err
);
  logic [NARROW_W-1:0] lane_word [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_slice
    assign lane_word[l] = in_data[l*NARROW_W +: NARROW_W];
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_op   <= in_op;
      out_sz   <= in_sz;
      out_src  <= in_src;
      out_data <= lane_word[in_lane];
      out_err  <= in_err;
    end
  end

  // R9: stalled response holds
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_src)
                                   && $stable(out_err)));
endmodule

// File: rtl/nw_width_bridge.sv
module nw_width_bridge #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 32,
  parameter int WIDE_W   = 128,
  parameter int HSRC_W   = 4,
  parameter int SLOTS    = 4,
  localparam int LANES   = WIDE_W / NARROW_W,
  localparam int LANE_W  = nw_pkg::idx_bits(LANES),
  localparam int OFS     = $clog2(NARROW_W / 8),
  localparam int SLOT_W  = nw_pkg::idx_bits(SLOTS),
  localparam int NMASK_W = NARROW_W / 8,
  localparam int WMASK_W = WIDE_W / 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                n_a_valid,
  output logic                n_a_ready,
  input  logic [2:0]          n_a_opcode,
  input  logic [2:0]          n_a_size,
  input  logic [HSRC_W-1:0]   n_a_source,
  input  logic [ADDR_W-1:0]   n_a_address,
  input  logic [NMASK_W-1:0]  n_a_mask,
  input  logic [NARROW_W-1:0] n_a_data,
  output logic                n_d_valid,
  input  logic                n_d_ready,
  output logic [2:0]          n_d_opcode,
  output logic [2:0]          n_d_size,
  output logic [HSRC_W-1:0]   n_d_source,
  output logic [NARROW_W-1:0] n_d_data,
  output logic                n_d_error,
  output logic                w_a_valid,
  input  logic                w_a_ready,
  output logic [2:0]          w_a_opcode,
  output logic [2:0]          w_a_size,
  output logic [SLOT_W-1:0]   w_a_source,
  output logic [ADDR_W-1:0]   w_a_address,
  output logic [WMASK_W-1:0]  w_a_mask,
  output logic [WIDE_W-1:0]   w_a_data,
  input  logic                w_d_valid,
  output logic                w_d_ready,
  input  logic [2:0]          w_d_opcode,
  input  logic [2:0]          w_d_size,
  input  logic [SLOT_W-1:0]   w_d_source,
  input  logic [WIDE_W-1:0]   w_d_data,
  input  logic                w_d_error
);
  logic              slot_avail;
  logic [SLOT_W-1:0] slot_idx;
  logic              pack_ready;
  logic              take_req;
  logic              take_rsp;
  logic [LANE_W-1:0] req_lane;
  logic [HSRC_W-1:0] rsp_src;
  logic [LANE_W-1:0] rsp_lane;

  assign req_lane  = n_a_address[OFS +: LANE_W];
  assign n_a_ready = pack_ready && slot_avail;
  assign take_req  = n_a_valid && n_a_ready;
  assign take_rsp  = w_d_valid && w_d_ready;

  nw_slot_table #(.SLOTS(SLOTS), .HSRC_W(HSRC_W), .LANE_W(LANE_W)) u_table (
    .clk(clk), .rst(rst),
    .alloc_en(take_req), .alloc_src(n_a_source), .alloc_lane(req_lane),
    .avail(slot_avail), .alloc_idx(slot_idx),
    .free_en(take_rsp), .free_idx(w_d_source),
    .rd_src(rsp_src), .rd_lane(rsp_lane)
  );

  nw_req_pack #(.ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .DSRC_W(SLOT_W)) u_pack (
    .clk(clk), .rst(rst),
    .in_valid(n_a_valid && slot_avail), .in_ready(pack_ready),
    .in_op(n_a_opcode), .in_sz(n_a_size), .in_src(slot_idx), .in_addr(n_a_address),
    .in_mask(n_a_mask), .in_data(n_a_data), .in_lane(req_lane),
    .out_valid(w_a_valid), .out_ready(w_a_ready),
    .out_op(w_a_opcode), .out_sz(w_a_size), .out_src(w_a_source), .out_addr(w_a_address),
    .out_mask(w_a_mask), .out_data(w_a_data)
  );

  nw_rsp_unpack #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .HSRC_W(HSRC_W)) u_unpack (
    .clk(clk), .rst(rst),
    .in_valid(w_d_valid), .in_ready(w_d_ready),
    .in_op(w_d_opcode), .in_sz(w_d_size), .in_err(w_d_error), .in_data(w_d_data),
    .in_src(rsp_src), .in_lane(rsp_lane),
    .out_valid(n_d_valid), .out_ready(n_d_ready),
    .out_op(n_d_opcode), .out_sz(n_d_size), .out_src(n_d_source),
    .out_data(n_d_data), .out_err(n_d_error)
  );

  // R1: idle outputs right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!w_a_valid && !n_d_valid));
  // R8: a full table blocks the host
  p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
    !slot_avail |-> !n_a_ready);
endmodule

// File: tb/tb_nw_width_bridge.sv
module tb_nw_width_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int HS = 4;
  localparam int DS = 2;
  localparam logic [2:0] OP_PUT_FULL = 3'd0, OP_PUT_PART = 3'd1, OP_GET = 3'd4;
  localparam logic [2:0] OP_ACK = 3'd0, OP_ACK_DATA = 3'd1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic n_a_valid = 0, n_a_ready;
  logic [2:0] n_a_opcode = 0, n_a_size = 0;
  logic [HS-1:0] n_a_source = 0;
  logic [31:0] n_a_address = 0;
  logic [3:0] n_a_mask = 0;
  logic [31:0] n_a_data = 0;
  logic n_d_valid, n_d_ready = 1;
  logic [2:0] n_d_opcode, n_d_size;
  logic [HS-1:0] n_d_source;
  logic [31:0] n_d_data;
  logic n_d_error;
  logic w_a_valid, w_a_ready = 1;
  logic [2:0] w_a_opcode, w_a_size;
  logic [DS-1:0] w_a_source;
  logic [31:0] w_a_address;
  logic [15:0] w_a_mask;
  logic [127:0] w_a_data;
  logic w_d_valid = 0, w_d_ready;
  logic [2:0] w_d_opcode = 0, w_d_size = 0;
  logic [DS-1:0] w_d_source = 0;
  logic [127:0] w_d_data = 0;
  logic w_d_error = 0;

  nw_width_bridge dut (.*);

  typedef struct {
    logic [2:0] op; logic [2:0] sz; logic [DS-1:0] src;
    logic [31:0] addr; logic [15:0] mask; logic [127:0] data;
  } wa_t;
  typedef struct {
    logic [2:0] op; logic [2:0] sz; logic [HS-1:0] src; logic [31:0] data; logic err;
  } nd_t;

  wa_t wa_q[$];
  nd_t nd_q[$];
  bit mb[SLOTS];
  logic [HS-1:0] s_hs[SLOTS];
  int s_ln[SLOTS];
  logic [2:0] s_sz[SLOTS];
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [127:0] mkw(input logic [31:0] seed);
    logic [127:0] w;
    for (int l = 0; l < 4; l++) w[l*32 +: 32] = seed + 32'h0101_0101 * l;
    return w;
  endfunction

  // driver: predicts the wide request, then performs the host handshake
  task automatic send_req(input logic [2:0] op, input logic [2:0] sz, input logic [HS-1:0] hs,
                          input logic [31:0] addr, input logic [3:0] mk, input logic [31:0] dt);
    wa_t e;
    int s;
    int ln;
    s = 0;
    for (int i = SLOTS - 1; i >= 0; i--) if (!mb[i]) s = i;
    ln = int'(addr[3:2]);
    e.op = op; e.sz = sz; e.src = DS'(s); e.addr = addr;
    e.mask = 16'(mk) << (4 * ln);
    e.data = 128'(dt) << (32 * ln);
    wa_q.push_back(e);
    mb[s] = 1; s_hs[s] = hs; s_ln[s] = ln; s_sz[s] = sz;
    @(negedge clk);
    n_a_valid = 1; n_a_opcode = op; n_a_size = sz; n_a_source = hs;
    n_a_address = addr; n_a_mask = mk; n_a_data = dt;
    #1;
    while (!n_a_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    n_a_valid = 0;
  endtask

  task automatic dev_respond(input int s, input logic [2:0] op, input logic er, input logic [127:0] dt);
    nd_t e;
    e.op = op; e.sz = s_sz[s]; e.src = s_hs[s]; e.err = er;
    e.data = 32'(dt >> (32 * s_ln[s]));
    nd_q.push_back(e);
    mb[s] = 0;
    @(negedge clk);
    w_d_valid = 1; w_d_opcode = op; w_d_size = s_sz[s]; w_d_source = DS'(s);
    w_d_data = dt; w_d_error = er;
    #1;
    while (!w_d_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    w_d_valid = 0;
  endtask

  // monitor on the wide request port
  always @(negedge clk) begin
    #2;
    if (!rst && w_a_valid && w_a_ready) begin
      if (wa_q.size() == 0) begin
        check(0, "R5", "unexpected wide request", 128'(w_a_address), 0);
      end else begin
        wa_t e;
        e = wa_q.pop_front();
        check(w_a_data == e.data, "R2", "w_a_data", w_a_data, e.data);
        check(w_a_mask == e.mask, "R3", "w_a_mask", 128'(w_a_mask), 128'(e.mask));
        check(w_a_address == e.addr && w_a_opcode == e.op && w_a_size == e.sz, "R4",
              "addr/op/size", {w_a_address, 5'd0, w_a_opcode, 5'd0, w_a_size},
              {e.addr, 5'd0, e.op, 5'd0, e.sz});
        check(w_a_source == e.src, "R5", "w_a_source", 128'(w_a_source), 128'(e.src));
      end
    end
  end

  // monitor on the narrow response port
  always @(negedge clk) begin
    #2;
    if (!rst && n_d_valid && n_d_ready) begin
      if (nd_q.size() == 0) begin
        check(0, "R7", "unexpected narrow response", 128'(n_d_source), 0);
      end else begin
        nd_t e;
        e = nd_q.pop_front();
        check(n_d_data == e.data, "R6", "n_d_data", 128'(n_d_data), 128'(e.data));
        check(n_d_source == e.src, "R7", "n_d_source", 128'(n_d_source), 128'(e.src));
        check(n_d_opcode == e.op && n_d_size == e.sz && n_d_error == e.err, "R7",
              "op/size/err", {n_d_opcode, n_d_size, n_d_error}, {e.op, e.sz, e.err});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] held;
    logic [31:0] held_n;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check(!w_a_valid && !n_d_valid, "R1", "valids in reset", {w_a_valid, n_d_valid}, 0);
    rst = 0;
    @(negedge clk); #1;
    check(!w_a_valid && !n_d_valid, "R1", "valids after reset", {w_a_valid, n_d_valid}, 0);
    check(n_a_ready, "R1", "n_a_ready after reset", 128'(n_a_ready), 1);

    // single transactions on each lane
    send_req(OP_PUT_FULL, 3'd2, 4'h5, 32'h0000_0000, 4'hF, 32'h1234_5678);
    repeat (2) @(negedge clk);
    dev_respond(0, OP_ACK, 1'b0, 128'd0);
    send_req(OP_PUT_PART, 3'd2, 4'h6, 32'h0003_0000, 4'h3, 32'hCAFE_0011);
    repeat (2) @(negedge clk);
    dev_respond(0, OP_ACK, 1'b0, 128'd0);
    send_req(OP_GET, 3'd2, 4'h1, 32'h0000_0008, 4'hF, 32'h0);
    repeat (2) @(negedge clk);
    dev_respond(0, OP_ACK_DATA, 1'b0, {32'hAAAA_AAAA, 32'h0000_0001, 32'hBBBB_BBBB, 32'hCCCC_CCCC});
    send_req(OP_PUT_PART, 3'd2, 4'h2, 32'h1000_0004, 4'h5, 32'h5555_AAAA);
    repeat (2) @(negedge clk);
    dev_respond(0, OP_ACK, 1'b1, 128'd0);
    send_req(OP_PUT_PART, 3'd1, 4'h3, 32'h1000_000C, 4'hC, 32'h9876_0000);
    repeat (2) @(negedge clk);
    dev_respond(0, OP_ACK, 1'b0, 128'd0);

    // fill every slot with reads to different lanes
    send_req(OP_GET, 3'd2, 4'hA, 32'h2000_000C, 4'hF, 0);
    send_req(OP_GET, 3'd2, 4'hB, 32'h2000_0008, 4'hF, 0);
    send_req(OP_GET, 3'd2, 4'hC, 32'h2000_0004, 4'hF, 0);
    send_req(OP_GET, 3'd2, 4'hD, 32'h2000_0000, 4'hF, 0);
    @(negedge clk);
    n_a_valid = 1; n_a_opcode = OP_GET; n_a_address = 32'h40; n_a_source = 4'hE;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(!n_a_ready, "R8", "ready while table full", 128'(n_a_ready), 0);
      @(negedge clk);
    end
    n_a_valid = 0;
    dev_respond(2, OP_ACK_DATA, 1'b0, mkw(32'h1100_0000));
    @(negedge clk); #1;
    check(n_a_ready, "R8", "ready after slot freed", 128'(n_a_ready), 1);
    send_req(OP_GET, 3'd2, 4'hE, 32'h2000_0008, 4'hF, 0);
    repeat (2) @(negedge clk);
    // out-of-order responses
    dev_respond(3, OP_ACK_DATA, 1'b0, mkw(32'h2200_0000));
    dev_respond(0, OP_ACK_DATA, 1'b0, mkw(32'h3300_0000));
    dev_respond(1, OP_ACK_DATA, 1'b1, mkw(32'h4400_0000));
    dev_respond(2, OP_ACK_DATA, 1'b0, mkw(32'h5500_0000));

    // backpressure on the wide request register
    w_a_ready = 0;
    send_req(OP_PUT_FULL, 3'd2, 4'h7, 32'h3000_0004, 4'hF, 32'hDEAD_BEEF);
    #1;
    held = w_a_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(w_a_valid && w_a_data == held, "R9", "wide request held", w_a_data, held);
    end
    w_a_ready = 1;
    repeat (2) @(negedge clk);

    // backpressure on the narrow response register
    n_d_ready = 0;
    dev_respond(0, OP_ACK_DATA, 1'b0, mkw(32'h6600_0000));
    #1;
    held_n = n_d_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check(n_d_valid && n_d_data == held_n, "R9", "narrow response held",
            128'(n_d_data), 128'(held_n));
    end
    n_d_ready = 1;

    for (int k = 0; k < 50 && (wa_q.size() != 0 || nd_q.size() != 0); k++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(wa_q.size() == 0, "R5", "pending wide requests", 128'(wa_q.size()), 0);
    check(nd_q.size() == 0, "R7", "pending narrow responses", 128'(nd_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule